// File: doc/BRIEF.md
# Successive-Approximation Converter Switch Sequencer

This block is the digital sequencer that sits beside a 16-bit charge-redistribution converter. It steps the switches of the capacitor array through a fixed sampling sequence and then runs one bit decision per clock. The sampling sequence has four steps. First, the two comparator inputs are shorted to the midpoint. Second, the binary-weighted array is returned to an all-reference state. Third, the signal is acquired onto the two sampling capacitors. Fourth, the short is released before the sampling capacitors leave the analog inputs. The conversion then takes one clock per bit, sixteen in total. The comparator decision is read at the end of each test cycle. Once all bits are resolved, the block goes straight back to sampling without any command.

The host pulses a start strobe. The sequencer holds the acquisition step until a start has been seen and the minimum acquisition time has elapsed. It then converts and presents the result with a one-cycle done pulse. The output code is the internal code with its top bit inverted, so it reads as a two's-complement value of the differential input. The lengths of the sampling steps are parameters. The analog array, the comparator and the reference buffer are outside this block.

Top module: `sar_switch_ctrl`

## Requirements
- R1: A synchronous reset puts the switches in the sampling-idle state on the next clock edge. In that state the short is closed (`short_mid_o`=1), both input selects are at ground (code 0), every array bit is at reference (`arr_ref_o` all ones), and `done_o` is low. The input select codes are 0 = ground, 1 = analog input and 2 = reference.
- R2: Each sampling sequence first holds the short closed with both input selects off the analog input for SHORT_CYC cycles. It then holds that state for RESET_CYC more cycles with every array bit at reference. Only after that do both input selects go to code 1, with the short still closed.
- R3: Acquisition lasts at least ACQ_CYC cycles. It continues for as long as no start strobe has been seen. A start seen during the short, array-reset or acquisition step is remembered and ends acquisition once the minimum has elapsed.
- R4: The short opens while both inputs are still on the analog input. That state lasts REL_CYC cycles. Only after it do the input selects leave code 1.
- R5: The negative input select is at ground (code 0) in every conversion cycle.
- R6: In the first test cycle, the positive select is at ground and all array bits are at reference. A decision of 1 leaves the positive select at ground, and a decision of 0 moves it to reference (code 2).
- R7: Array bit j (`arr_ref_o[j]`, 1 = reference) is tested in conversion cycle 15-j by pulling it to ground. The test starts on the same edge that latches the previous decision. A decision of 1 keeps that bit at ground and a decision of 0 returns it to reference.
- R8: In the cycle after the 16th test cycle, `done_o` is high for exactly one cycle. In that cycle `result_o` equals the internal code (one decision per bit, MSB first) with bit 15 inverted.
- R9: The done cycle is already the first cycle of a new sampling sequence. Until the array-reset step, the positive select and the array bits keep the switch positions of the finished conversion.
- R10: A start strobe that arrives during the release step or the conversion has no effect. No extra conversion follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request strobe |
| cmp_i | input | 1 | Comparator decision, 1 = positive node below negative node |
| short_mid_o | output | 1 | Closes both comparator-to-midpoint switches |
| pos_sel_o | output | 2 | Positive sampling capacitor: 0 ground, 1 analog input, 2 reference |
| neg_sel_o | output | 2 | Negative sampling capacitor: 0 ground, 1 analog input |
| arr_ref_o | output | N_BITS-1 | Array switch per bit, 1 = reference, 0 = ground |
| result_o | output | N_BITS | Converted code with inverted top bit |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
The bench replaces the analog array with an ideal integer comparator. The comparator compares the applied code with the trial code that the switch outputs currently select. The converted result must therefore reproduce the applied code exactly. The applied codes are the two ends of the range and the values on either side of mid-scale, which separate a wrong MSB inversion from a wrong decision rule. Alternating-bit codes expose swapped or shifted array indices, and a multiplicative stride over 256 further codes covers mixed patterns. In every conversion the switch pattern is checked cycle by cycle against the pattern expected from the applied code, which catches a bit tested one cycle early or late. Separate runs cover start strobes placed in each sampling step, in the release step and in the conversion, an acquisition held without start, and a reset in the middle of a conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        PH_SHORT = 3'd0,
        PH_ARST  = 3'd1,
        PH_ACQ   = 3'd2,
        PH_REL   = 3'd3,
        PH_CONV  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        SW_GND = 2'd0,
        SW_AIN = 2'd1,
        SW_REF = 2'd2
    } inpos_e;

    typedef struct packed {
        logic   short_on;
        inpos_e pos;
        inpos_e neg;
    } front_t;

    function automatic logic is_sampling(input phase_e p);
        return (p == PH_SHORT) || (p == PH_ARST) || (p == PH_ACQ);
    endfunction

    function automatic logic on_input(input phase_e p);
        return (p == PH_ACQ) || (p == PH_REL);
    endfunction

endpackage

// File: rtl/sar_phase_seq.sv
module sar_phase_seq
    import sar_seq_pkg::*;
#(
    parameter int N_BITS    = 16,
    parameter int CNT_W     = 8,
    parameter int SHORT_CYC = 4,
    parameter int RESET_CYC = 4,
    parameter int ACQ_CYC   = 16,
    parameter int REL_CYC   = 2,
    localparam int IDX_W    = $clog2(N_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output phase_e           phase_o,
    output logic [IDX_W-1:0] bit_idx_o
);

    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] ARST_LIM  = CNT_W'(RESET_CYC - 1);
    localparam logic [CNT_W-1:0] ACQ_LIM   = CNT_W'(ACQ_CYC - 1);
    localparam logic [CNT_W-1:0] REL_LIM   = CNT_W'(REL_CYC - 1);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(N_BITS - 1);

    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             lim_hit;
    logic [IDX_W-1:0] idx_q;
    logic             pend_q;

    always_comb begin
        unique case (phase_q)
            PH_SHORT: lim = SHORT_LIM;
            PH_ARST:  lim = ARST_LIM;
            PH_ACQ:   lim = ACQ_LIM;
            PH_REL:   lim = REL_LIM;
            default:  lim = '0;
        endcase
    end

    assign lim_hit = (cnt_q >= lim);

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_SHORT: if (lim_hit) phase_d = PH_ARST;
            PH_ARST:  if (lim_hit) phase_d = PH_ACQ;
            PH_ACQ:   if (lim_hit && (pend_q || start_i)) phase_d = PH_REL;
            PH_REL:   if (lim_hit) phase_d = PH_CONV;
            PH_CONV:  if (idx_q == LAST_IDX) phase_d = PH_SHORT;
            default:  phase_d = PH_SHORT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_SHORT;
            cnt_q   <= '0;
            idx_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (phase_d != phase_q) begin
                cnt_q <= '0;
            end else if (!lim_hit) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (phase_q == PH_CONV && phase_d == PH_CONV) begin
                idx_q <= idx_q + 1'b1;
            end else begin
                idx_q <= '0;
            end
            if (phase_q == PH_ACQ && phase_d != PH_ACQ) begin
                pend_q <= 1'b0;
            end else if (is_sampling(phase_q) && start_i) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign phase_o   = phase_q;
    assign bit_idx_o = idx_q;

    // R2
    acq_after_arst_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ACQ && $past(phase_q) != PH_ACQ) |-> $past(phase_q) == PH_ARST);

    // R3
    acq_min_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ACQ) |=> (phase_q == PH_ACQ || $past(cnt_q) == ACQ_LIM));

    // R4
    rel_after_acq_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_REL && $past(phase_q) != PH_REL) |-> $past(phase_q) == PH_ACQ);

    // R10
    no_pend_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_REL || phase_q == PH_CONV) |-> !pend_q);

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
    import sar_seq_pkg::*;
#(
    parameter int N_BITS = 16,
    localparam int IDX_W = $clog2(N_BITS),
    localparam int ARR_W = N_BITS - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    input  logic              cmp_i,
    output logic [ARR_W-1:0]  arr_q_o,
    output logic              pos_ref_o,
    output logic [N_BITS-1:0] result_o,
    output logic              done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BITS - 1);

    logic [ARR_W-1:0]  arr_q;
    logic              pos_ref_q;
    logic [N_BITS-1:0] dec_q;
    logic [N_BITS-1:0] raw_code;
    logic [N_BITS-1:0] result_q;
    logic              done_q;

    assign raw_code = {dec_q[N_BITS-1:1], cmp_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_q     <= '1;
            pos_ref_q <= 1'b0;
            dec_q     <= '0;
            result_q  <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_i)
                PH_ARST: arr_q <= '1;
                PH_ACQ, PH_REL: pos_ref_q <= 1'b0;
                PH_CONV: begin
                    for (int b = 0; b < N_BITS; b++) begin
                        if (bit_idx_i == IDX_W'(N_BITS - 1 - b)) dec_q[b] <= cmp_i;
                    end
                    if (bit_idx_i == '0) pos_ref_q <= ~cmp_i;
                    for (int j = 0; j < ARR_W; j++) begin
                        if (bit_idx_i == IDX_W'(N_BITS - 1 - j)) arr_q[j] <= ~cmp_i;
                        if (bit_idx_i == IDX_W'(N_BITS - 2 - j)) arr_q[j] <= 1'b0;
                    end
                    if (bit_idx_i == LAST_IDX) begin
                        result_q <= {~raw_code[N_BITS-1], raw_code[N_BITS-2:0]};
                        done_q   <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign arr_q_o   = arr_q;
    assign pos_ref_o = pos_ref_q;
    assign result_o  = result_q;
    assign done_o    = done_q;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R6
    msb_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_CONV && bit_idx_i == '0) |=> (pos_ref_q == !$past(cmp_i)));

    // R7
    next_bit_ground_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_CONV && bit_idx_i == '0) |=> (arr_q[ARR_W-1] == 1'b0));

endmodule

// File: rtl/sar_switch_map.sv
module sar_switch_map
    import sar_seq_pkg::*;
#(
    parameter int N_BITS = 16,
    localparam int ARR_W = N_BITS - 1
) (
    input  phase_e           phase_i,
    input  logic             pos_ref_i,
    input  logic [ARR_W-1:0] arr_q_i,
    output front_t           front_o,
    output logic [ARR_W-1:0] arr_o
);

    always_comb begin
        front_o.short_on = is_sampling(phase_i);
        if (on_input(phase_i)) begin
            front_o.pos = SW_AIN;
            front_o.neg = SW_AIN;
        end else begin
            front_o.pos = pos_ref_i ? SW_REF : SW_GND;
            front_o.neg = SW_GND;
        end
        arr_o = (phase_i == PH_ARST) ? '1 : arr_q_i;
    end

endmodule

// File: rtl/sar_switch_ctrl.sv
module sar_switch_ctrl
    import sar_seq_pkg::*;
#(
    parameter int N_BITS    = 16,
    parameter int CNT_W     = 8,
    parameter int SHORT_CYC = 4,
    parameter int RESET_CYC = 4,
    parameter int ACQ_CYC   = 16,
    parameter int REL_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cmp_i,
    output logic              short_mid_o,
    output logic [1:0]        pos_sel_o,
    output logic [1:0]        neg_sel_o,
    output logic [N_BITS-2:0] arr_ref_o,
    output logic [N_BITS-1:0] result_o,
    output logic              done_o
);

    localparam int IDX_W = $clog2(N_BITS);
    localparam int ARR_W = N_BITS - 1;

    phase_e           phase;
    logic [IDX_W-1:0] bit_idx;
    logic [ARR_W-1:0] arr_q;
    logic             pos_ref;
    front_t           front;

    sar_phase_seq #(
        .N_BITS(N_BITS), .CNT_W(CNT_W), .SHORT_CYC(SHORT_CYC),
        .RESET_CYC(RESET_CYC), .ACQ_CYC(ACQ_CYC), .REL_CYC(REL_CYC)
    ) seq_i (
        .clk(clk), .rst(rst), .start_i(start_i),
        .phase_o(phase), .bit_idx_o(bit_idx)
    );

    sar_bit_engine #(.N_BITS(N_BITS)) eng_i (
        .clk(clk), .rst(rst), .phase_i(phase), .bit_idx_i(bit_idx),
        .cmp_i(cmp_i), .arr_q_o(arr_q), .pos_ref_o(pos_ref),
        .result_o(result_o), .done_o(done_o)
    );

    sar_switch_map #(.N_BITS(N_BITS)) map_i (
        .phase_i(phase), .pos_ref_i(pos_ref), .arr_q_i(arr_q),
        .front_o(front), .arr_o(arr_ref_o)
    );

    assign short_mid_o = front.short_on;
    assign pos_sel_o   = front.pos;
    assign neg_sel_o   = front.neg;

    // R4
    release_order_chk: assert property (@(posedge clk) disable iff (rst)
        (!short_mid_o && $past(short_mid_o)) |-> (pos_sel_o == SW_AIN && neg_sel_o == SW_AIN));

    // R5
    neg_ground_conv_chk: assert property (@(posedge clk) disable iff (rst)
        (!short_mid_o && pos_sel_o != SW_AIN) |-> (neg_sel_o == SW_GND));

    // R9
    done_in_sampling_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (short_mid_o && pos_sel_o != SW_AIN));

endmodule

// File: tb/sar_switch_ctrl_tb_top.sv
module sar_switch_ctrl_tb_top;

    localparam int NB = 16;
    localparam int SC = 2;
    localparam int RC = 3;
    localparam int AC = 4;
    localparam int LC = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          cmp;
    logic          short_mid;
    logic [1:0]    pos_sel;
    logic [1:0]    neg_sel;
    logic [NB-2:0] arr;
    logic [NB-1:0] result;
    logic          done;
    logic [15:0]   cur_x = 16'h0000;

    always #5 clk = ~clk;

    sar_switch_ctrl #(
        .N_BITS(NB), .CNT_W(8), .SHORT_CYC(SC), .RESET_CYC(RC),
        .ACQ_CYC(AC), .REL_CYC(LC)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .cmp_i(cmp),
        .short_mid_o(short_mid), .pos_sel_o(pos_sel), .neg_sel_o(neg_sel),
        .arr_ref_o(arr), .result_o(result), .done_o(done)
    );

    // ideal array: trial code = {MSB cap on ground, array bits on ground}
    assign cmp = (cur_x >= {(pos_sel == 2'd0), ~arr});

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    int conv_k = -1;
    int pre_run = 0;
    int acq_run = 0;
    int rel_run = 0;
    bit pre_valid = 0;
    bit prev_short = 1;
    bit prev_done = 0;

    always @(negedge clk) begin
        if (rst) begin
            conv_k = -1; pre_run = 0; acq_run = 0; rel_run = 0;
            pre_valid = 0; prev_short = 1; prev_done = 0;
        end else begin
            if (done) begin
                done_cnt++;
                chk(result == (cur_x ^ 16'h8000), "R8 result code", result, cur_x ^ 16'h8000);
                chk(!prev_done, "R8 single-cycle done", 1, 0);
                chk(conv_k == 16, "R8 done timing", conv_k, 16);
                chk(short_mid && pos_sel != 2'd1, "R9 auto return to sampling", short_mid, 1);
                chk(arr == ~cur_x[14:0], "R9 array held", arr, ~cur_x[14:0]);
                chk(pos_sel == (cur_x[15] ? 2'd0 : 2'd2), "R9 msb switch held", pos_sel,
                    cur_x[15] ? 0 : 2);
                pre_valid = 1;
                pre_run = 0;
            end else if (conv_k == 16) begin
                chk(1'b0, "R8 done missing", 0, 1);
            end
            if (conv_k == 16) conv_k = -1;

            if (prev_short && !short_mid) begin
                chk(acq_run >= AC, "R3 minimum acquisition", acq_run, AC);
                chk(pos_sel == 2'd1 && neg_sel == 2'd1, "R4 short opens first", pos_sel, 1);
                acq_run = 0;
            end

            if (conv_k < 0 && !short_mid && pos_sel != 2'd1) begin
                chk(rel_run == LC, "R4 release length", rel_run, LC);
                rel_run = 0;
                conv_k = 0;
            end

            if (conv_k >= 0) begin
                logic [14:0] ea;
                logic [1:0]  ep;
                for (int j = 0; j < 15; j++) begin
                    if (j > 15 - conv_k) ea[j] = ~cur_x[j];
                    else if (j == 15 - conv_k) ea[j] = 1'b0;
                    else ea[j] = 1'b1;
                end
                ep = (conv_k == 0) ? 2'd0 : (cur_x[15] ? 2'd0 : 2'd2);
                chk(neg_sel == 2'd0, "R5 negative at ground", neg_sel, 0);
                chk(pos_sel == ep, (conv_k == 0) ? "R6 first test" : "R6 msb rule", pos_sel, ep);
                chk(arr == ea, "R7 array pattern", arr, ea);
                chk(!short_mid, "R4 short open in conversion", short_mid, 0);
                conv_k++;
            end else if (!short_mid) begin
                rel_run++;
                chk(pos_sel == 2'd1 && neg_sel == 2'd1, "R4 inputs held in release", pos_sel, 1);
            end else if (pos_sel == 2'd1) begin
                if (pre_run > 0) begin
                    if (pre_valid) chk(pre_run == SC + RC, "R2 short plus reset length", pre_run, SC + RC);
                    chk(arr == '1, "R2 array at reference", arr, 16'h7fff);
                    chk(neg_sel == 2'd1, "R2 both inputs connect", neg_sel, 1);
                    pre_run = 0;
                end
                acq_run++;
            end else begin
                pre_run++;
            end
            prev_short = short_mid;
            prev_done = done;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_acq(input string tag);
        int n = 0;
        while (!(short_mid && pos_sel == 2'd1) && n < 200) begin step(); n++; end
        if (n >= 200) chk(1'b0, tag, 0, 1);
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 200) begin step(); n++; end
        if (n >= 200) chk(1'b0, tag, 0, 1);
    endtask

    task automatic do_conv(input logic [15:0] x);
        cur_x = x;
        wait_acq("R3 acquisition reached");
        start = 1'b1;
        step();
        start = 1'b0;
        wait_done("R8 conversion finished");
        step();
    endtask

    task automatic chk_idle(input string tag);
        chk(short_mid == 1'b1, tag, short_mid, 1);
        chk(pos_sel == 2'd0 && neg_sel == 2'd0, tag, pos_sel, 0);
        chk(arr == '1, tag, arr, 16'h7fff);
        chk(done == 1'b0, tag, done, 0);
    endtask

    initial begin
        int base;
        repeat (3) step();
        chk_idle("R1 reset state");
        rst = 1'b0;

        do_conv(16'h1234);
        do_conv(16'h0000);
        do_conv(16'h0001);
        do_conv(16'h7fff);
        do_conv(16'h8000);
        do_conv(16'h8001);
        do_conv(16'hffff);
        do_conv(16'haaaa);
        do_conv(16'h5555);
        for (int i = 0; i < 256; i++) begin
            do_conv(16'((i * 40503 + 77) & 16'hffff));
        end

        // R3: no start, acquisition must hold
        base = done_cnt;
        repeat (AC * 4 + 10) step();
        chk(short_mid && pos_sel == 2'd1, "R3 holds acquisition", pos_sel, 1);
        chk(done_cnt == base, "R3 no conversion without start", done_cnt, base);

        // R10: starts in release and conversion are ignored
        cur_x = 16'h3c5a;
        start = 1'b1; step(); start = 1'b0;
        while (short_mid) step();
        start = 1'b1; step(); start = 1'b0;
        while (pos_sel == 2'd1) step();
        step(); step();
        start = 1'b1; step(); start = 1'b0;
        wait_done("R10 conversion finished");
        base = done_cnt;
        repeat (40) step();
        chk(done_cnt == base, "R10 late start ignored", done_cnt, base);
        chk(short_mid && pos_sel == 2'd1, "R10 stays in acquisition", pos_sel, 1);

        // R3: start during the short step is remembered
        cur_x = 16'hc3a5;
        start = 1'b1; step(); start = 1'b0;
        wait_done("R3 first of pair");
        start = 1'b1; step(); start = 1'b0;
        base = done_cnt;
        wait_done("R3 pended start converts");
        step();
        chk(done_cnt == base + 1, "R3 pended start converts", done_cnt, base + 1);

        // R1: reset in the middle of a conversion
        cur_x = 16'h0f0f;
        wait_acq("R1 acquisition before reset");
        start = 1'b1; step(); start = 1'b0;
        while (short_mid) step();
        repeat (LC + 5) step();
        rst = 1'b1;
        step();
        chk_idle("R1 reset mid-conversion");
        step();
        rst = 1'b0;
        do_conv(16'hf0f0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule